// File: doc/BRIEF.md
# Bus Master Error Capture Controller

This block sits beside a DMA bus master and watches it for five fault conditions: a target abort, a target that never answers with device select, a parity mismatch on read data, a transfer started while mastering is turned off, and a loss of step between the DMA engine and the master logic. Each fault pulse latches its own sticky flag and a common summary flag. The summary flag drives the bus-error interrupt. While any flag is set, the halt output is high and no further command is granted to the master.

The faults fall into two classes. The three protocol faults (target abort, no response and parity) can be cleared by software with a write-one-to-clear access. The two internal faults (mastering disabled and sync loss) ignore that write. They clear only through a global soft-reset command, an error-reset command or the active-low hardware reset pin. The summary flag has a clear of its own, and that clear is accepted only once every specific flag has already gone. This forces software to clear in a fixed order: the source flags first, then the summary.

The register write port is one 8-bit word. Bit 7 is the error-reset command and bit 6 is the global soft-reset command. Bit 5 is the summary flag. Bits 4 to 0 are the specific flags: 4 target abort, 3 no response, 2 parity, 1 mastering disabled, 0 sync loss. The status field output uses the same bit order.

Top module: `bmerr_capture`

## Requirements
- R1: A one-cycle pulse on a fault input sets that fault's flag at the next rising clock edge. Flag bit positions are 4 target abort, 3 no response, 2 parity, 1 mastering disabled, 0 sync loss. The status field output shows the same bits in the same positions.
- R2: Any fault pulse also sets the summary flag at the same edge, and the interrupt output equals the summary flag.
- R3: Halt is high exactly while any specific flag or the summary flag is set. The command grant equals the command request when halt is low and is 0 when halt is high.
- R4: A register write with a 1 in bit 4, 3 or 2 clears the matching protocol flag at the next edge.
- R5: A register write with 1s in bits 1 and 0 leaves the mastering-disabled and sync-loss flags unchanged.
- R6: A 1 in write bit 5 clears the summary flag only if no specific flag was set before that write. Otherwise it is ignored, and this includes a write that clears the last flags in the same access.
- R7: Bits written as 0 have no effect on any flag.
- R8: A 1 in write bit 6 (global soft reset) clears all specific flags and the summary flag.
- R9: A 1 in write bit 7 (error reset) clears all specific flags and the summary flag.
- R10: A low level on the hardware reset pin clears every flag at once, without waiting for a clock edge.
- R11: When a fault pulse and any clear of the same flag fall in the same cycle, the fault wins and the flag (and the summary) stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Active-low hardware reset pin, asynchronous |
| flt_tabort | input | 1 | Target abort seen on the bus |
| flt_noresp | input | 1 | Addressed target gave no device select |
| flt_parity | input | 1 | Read data parity mismatch |
| flt_disabled | input | 1 | Transfer attempted while mastering is disabled |
| flt_syncloss | input | 1 | DMA engine and master logic lost step |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data (bit map in R1, R6, R8, R9) |
| cmd_req | input | 1 | Master asks to accept a new command |
| cmd_grant | output | 1 | Command accepted (request and not halted) |
| err_flags | output | 5 | Specific sticky flags |
| sys_stat | output | 5 | System status field, same bit order as the flags |
| sum_err | output | 1 | Summary error flag |
| bus_err_irq | output | 1 | Bus-error interrupt |
| halt | output | 1 | Master is stopped |

## Verification
A new fault and a software clear of the same flag can land in the same cycle. So can a fault and a soft-reset or error-reset command. The bench provokes this by raising a fault input on the same clock as a register write that targets that flag, the summary flag or all flags. It judges the flag and summary one cycle later against R11: they must still be set, with halt high and grant low. A second collision sets a protocol flag's clear and the summary clear in one write. It expects the flag to go and the summary to stay, as R6 requires.

// File: rtl/bmerr_pkg.sv
package bmerr_pkg;
  localparam int NSRC     = 5;
  localparam int REG_W    = 8;
  localparam int B_TABORT = 4;
  localparam int B_NORESP = 3;
  localparam int B_PARITY = 2;
  localparam int B_DISAB  = 1;
  localparam int B_SYNC   = 0;
  localparam int B_SUM    = 5;
  localparam int B_GRST   = 6;
  localparam int B_ERST   = 7;

  // Protocol-class sources may be cleared by software.
  function automatic logic sw_clearable(input int idx);
    return (idx == B_TABORT) || (idx == B_NORESP) || (idx == B_PARITY);
  endfunction

  // Per-source write-one-to-clear request, masked by class.
  function automatic logic [NSRC-1:0] w1c_hits(input logic we,
                                              input logic [REG_W-1:0] d);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++) r[i] = we & d[i] & sw_clearable(i);
    return r;
  endfunction

  // Global clear command: soft reset or error reset bit.
  function automatic logic hard_clear(input logic we,
                                      input logic [REG_W-1:0] d);
    return we & (d[B_GRST] | d[B_ERST]);
  endfunction
endpackage

// File: rtl/bmerr_flag_cell.sv
module bmerr_flag_cell #(
  parameter bit SW_CLR = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic w1c_i,
  input  logic hard_clr_i,
  output logic q_o
);
  logic clr;

  generate
    if (SW_CLR) begin : g_proto
      assign clr = hard_clr_i | w1c_i;
    end else begin : g_internal
      logic unused_w1c;
      assign unused_w1c = w1c_i;
      assign clr = hard_clr_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr)    q_o <= 1'b0;
  end
endmodule

// File: rtl/bmerr_summary.sv
module bmerr_summary (
  input  logic clk,
  input  logic rst_n,
  input  logic any_set_i,
  input  logic flags_busy_i,
  input  logic w1c_i,
  input  logic hard_clr_i,
  output logic q_o
);
  logic ordered_clr;
  assign ordered_clr = w1c_i & ~flags_busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       q_o <= 1'b0;
    else if (any_set_i)               q_o <= 1'b1;
    else if (hard_clr_i | ordered_clr) q_o <= 1'b0;
  end
endmodule

// File: rtl/bmerr_halt_gate.sv
module bmerr_halt_gate #(
  parameter int NSRC = 5
) (
  input  logic [NSRC-1:0] flags_i,
  input  logic            sum_i,
  input  logic            cmd_req_i,
  output logic            halt_o,
  output logic            cmd_grant_o
);
  always_comb begin
    halt_o      = (|flags_i) | sum_i;
    cmd_grant_o = cmd_req_i & ~halt_o;
  end
endmodule

// File: rtl/bmerr_capture.sv
module bmerr_capture
  import bmerr_pkg::*;
#(
  parameter int N_SRC = bmerr_pkg::NSRC,
  parameter int WR_W  = bmerr_pkg::REG_W
) (
  input  logic             clk,
  input  logic             hw_rst_n,
  input  logic             flt_tabort,
  input  logic             flt_noresp,
  input  logic             flt_parity,
  input  logic             flt_disabled,
  input  logic             flt_syncloss,
  input  logic             wr_en,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             cmd_req,
  output logic             cmd_grant,
  output logic [N_SRC-1:0] err_flags,
  output logic [N_SRC-1:0] sys_stat,
  output logic             sum_err,
  output logic             bus_err_irq,
  output logic             halt
);
  // Named internal events, visible to the bound checker.
  logic [N_SRC-1:0] fault_vec;
  logic [N_SRC-1:0] sw_clr_vec;
  logic             hard_clr;
  logic             sum_clr_req;
  logic             any_fault;

  always_comb begin
    fault_vec           = '0;
    fault_vec[B_TABORT] = flt_tabort;
    fault_vec[B_NORESP] = flt_noresp;
    fault_vec[B_PARITY] = flt_parity;
    fault_vec[B_DISAB]  = flt_disabled;
    fault_vec[B_SYNC]   = flt_syncloss;
  end

  assign sw_clr_vec  = w1c_hits(wr_en, wr_data);
  assign hard_clr    = hard_clear(wr_en, wr_data);
  assign sum_clr_req = wr_en & wr_data[B_SUM];
  assign any_fault   = |fault_vec;

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_src
      bmerr_flag_cell #(.SW_CLR(sw_clearable(gi))) u_cell (
        .clk       (clk),
        .rst_n     (hw_rst_n),
        .set_i     (fault_vec[gi]),
        .w1c_i     (sw_clr_vec[gi]),
        .hard_clr_i(hard_clr),
        .q_o       (err_flags[gi])
      );
    end
  endgenerate

  bmerr_summary u_sum (
    .clk         (clk),
    .rst_n       (hw_rst_n),
    .any_set_i   (any_fault),
    .flags_busy_i(|err_flags),
    .w1c_i       (sum_clr_req),
    .hard_clr_i  (hard_clr),
    .q_o         (sum_err)
  );

  bmerr_halt_gate #(.NSRC(N_SRC)) u_gate (
    .flags_i    (err_flags),
    .sum_i      (sum_err),
    .cmd_req_i  (cmd_req),
    .halt_o     (halt),
    .cmd_grant_o(cmd_grant)
  );

  assign sys_stat    = err_flags;
  assign bus_err_irq = sum_err;
endmodule

// File: rtl/bmerr_capture_chk.sv
module bmerr_capture_chk #(
  parameter int N_SRC = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] fault_vec,
  input logic [N_SRC-1:0] flags,
  input logic             sum_err,
  input logic             halt,
  input logic             cmd_grant,
  input logic             hard_clr,
  input logic             sum_clr_req
);
  AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_vec) |=> ((flags & $past(fault_vec)) == $past(fault_vec))); // R11

  AST_SUM_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_vec) |=> sum_err); // R2

  AST_INTERNAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !hard_clr |=> ((flags[1:0] & $past(flags[1:0])) == $past(flags[1:0]))); // R5

  AST_SUM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_err && (|flags) && !hard_clr) |=> sum_err); // R6

  AST_NO_GRANT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !cmd_grant); // R3

  AST_SUM_CLR_NOFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_clr_req && !(|flags) && !(|fault_vec)) |=> !sum_err); // R6
endmodule

bind bmerr_capture bmerr_capture_chk #(.N_SRC(N_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (hw_rst_n),
  .fault_vec  (fault_vec),
  .flags      (err_flags),
  .sum_err    (sum_err),
  .halt       (halt),
  .cmd_grant  (cmd_grant),
  .hard_clr   (hard_clr),
  .sum_clr_req(sum_clr_req)
);

// File: tb/tb_bmerr_capture.sv
`timescale 1ns/1ps
module tb_bmerr_capture;
  logic       clk = 1'b0;
  logic       hw_rst_n = 1'b0;
  logic [4:0] flt = '0;   // {tabort, noresp, parity, disabled, syncloss}
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmd_req = 1'b1;
  logic       cmd_grant, sum_err, bus_err_irq, halt;
  logic [4:0] err_flags, sys_stat;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bmerr_capture dut (
    .clk(clk), .hw_rst_n(hw_rst_n),
    .flt_tabort(flt[4]), .flt_noresp(flt[3]), .flt_parity(flt[2]),
    .flt_disabled(flt[1]), .flt_syncloss(flt[0]),
    .wr_en(wr_en), .wr_data(wr_data), .cmd_req(cmd_req),
    .cmd_grant(cmd_grant), .err_flags(err_flags), .sys_stat(sys_stat),
    .sum_err(sum_err), .bus_err_irq(bus_err_irq), .halt(halt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Whole visible state against expectations; halt/grant derived from R3.
  task automatic expect_state(input string req, input logic [4:0] f, input logic s);
    logic h;
    h = (f != 0) || s;
    chk({req, " flags"}, err_flags, f);
    chk({req, " sys_stat"}, sys_stat, f);
    chk({req, " sum"}, sum_err, s);
    chk({req, " irq"}, bus_err_irq, s);
    chk({req, " R3 halt"}, halt, h);
    chk({req, " R3 grant"}, cmd_grant, cmd_req & ~h);
  endtask

  // One cycle of stimulus, applied at negedge, result sampled at the next negedge.
  task automatic step(input logic [4:0] f, input logic we, input logic [7:0] d);
    @(negedge clk);
    flt = f; wr_en = we; wr_data = d;
    @(negedge clk);
    flt = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    hw_rst_n = 1'b0;
    #2;
    expect_state("R10 async", 5'b0, 1'b0);
    @(negedge clk);
    hw_rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    expect_state("R10 reset", 5'b0, 1'b0);
    cmd_req = 1'b0; #1;
    chk("R3 grant idle req0", cmd_grant, 1'b0);
    cmd_req = 1'b1; #1;
    chk("R3 grant idle req1", cmd_grant, 1'b1);
  endtask

  task automatic t_each_fault();
    for (int i = 0; i < 5; i++) begin
      hw_reset();
      step(5'b1 << i, 1'b0, 8'h00);
      expect_state("R1 R2 single fault", 5'b1 << i, 1'b1);
    end
    hw_reset();
    step(5'b10101, 1'b0, 8'h00);
    expect_state("R1 multi fault", 5'b10101, 1'b1);
  endtask

  task automatic t_proto_w1c();
    hw_reset();
    step(5'b11100, 1'b0, 8'h00);
    step(5'b0, 1'b1, 8'h10);
    expect_state("R4 clear tabort", 5'b01100, 1'b1);
    step(5'b0, 1'b1, 8'h0C);
    expect_state("R4 clear noresp+parity", 5'b0, 1'b1);
    step(5'b0, 1'b1, 8'h20);
    expect_state("R6 summary cleared last", 5'b0, 1'b0);
  endtask

  task automatic t_zero_write();
    hw_reset();
    step(5'b11111, 1'b0, 8'h00);
    step(5'b0, 1'b1, 8'h00);
    expect_state("R7 zero write", 5'b11111, 1'b1);
  endtask

  task automatic t_internal();
    hw_reset();
    step(5'b00011, 1'b0, 8'h00);
    step(5'b0, 1'b1, 8'h3F);
    expect_state("R5 internal ignore w1c", 5'b00011, 1'b1);
    step(5'b0, 1'b1, 8'h40);
    expect_state("R8 global soft reset", 5'b0, 1'b0);
    step(5'b11111, 1'b0, 8'h00);
    step(5'b0, 1'b1, 8'h80);
    expect_state("R9 error reset", 5'b0, 1'b0);
  endtask

  task automatic t_order();
    hw_reset();
    step(5'b00100, 1'b0, 8'h00);
    step(5'b0, 1'b1, 8'h20);
    expect_state("R6 summary while flag set", 5'b00100, 1'b1);
    step(5'b0, 1'b1, 8'h24);
    expect_state("R6 summary same write as flag", 5'b0, 1'b1);
  endtask

  task automatic t_collision();
    hw_reset();
    step(5'b00100, 1'b0, 8'h00);
    step(5'b00100, 1'b1, 8'h04);
    expect_state("R11 fault vs w1c", 5'b00100, 1'b1);
    step(5'b01000, 1'b1, 8'h80);
    expect_state("R11 fault vs error reset", 5'b01000, 1'b1);
    step(5'b00001, 1'b1, 8'h40);
    expect_state("R11 fault vs soft reset", 5'b00001, 1'b1);
    step(5'b0, 1'b1, 8'h80);
    expect_state("R9 clear after collision", 5'b0, 1'b0);
    step(5'b10000, 1'b1, 8'h20);
    expect_state("R11 fault vs summary clear", 5'b10000, 1'b1);
  endtask

  task automatic t_hw_pin();
    step(5'b11111, 1'b0, 8'h00);
    expect_state("R10 pre pin", 5'b11111, 1'b1);
    hw_reset();
    expect_state("R10 after pin", 5'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    hw_rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_each_fault();
    t_proto_w1c();
    t_zero_write();
    t_internal();
    t_order();
    t_collision();
    t_hw_pin();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule